// File: doc/BRIEF.md
# Processor Health Supervisor

This block watches over a processor on the same chip. Two single-cycle strobes report that the foreground stack or the background stack has run past its limit. Each report is latched into a sticky flag, and any set flag drives an interrupt line until software clears it. When both flags are set at once, the supervisor issues a hard reset pulse of fixed length. A configuration bit can mask that reset so that only the interrupt remains.

The same block holds a watchdog. Software arms it through the configuration word and must then kick it at least once per programmed interval. A missed kick also triggers the hard reset pulse. A free-running reference timer counts every clock, and its value is always visible at an output. The hard reset pulse clears the flags, the watchdog count and the timer. It leaves the configuration word untouched.

Top module: `health_supervisor`

## Requirements
- R1: A high strobe on `fg_ovf` or `bg_ovf` sets that stack's sticky flag at the next clock edge. `irq` is high from that edge onward for as long as either flag is set.
- R2: A high `irq_clr` clears both flags at the clock edge. If an overflow strobe arrives in the same cycle as the clear, the strobe wins and its flag stays set.
- R3: While both flags are set, the overflow-reset mask is 0 and no pulse is running, `hard_rst` rises at the next clock edge.
- R4: While the mask bit is 1, having both flags set never raises `hard_rst`, and `irq` stays high.
- R5: `hard_rst` stays high for exactly `PULSE_LEN` cycles (default 16). Any trigger during the pulse is ignored, and both flags and `irq` are low once the pulse ends.
- R6: After `rst_n` the watchdog is disarmed, and missing kicks cause no reset until the enable bit is written as 1.
- R7: A configuration write or a kick loads the watchdog with interval I. A kick in the I+1'th cycle after it is still in time. With no kick, `hard_rst` rises at the end of that cycle.
- R8: A hard reset pulse does not alter the configuration word. An armed watchdog stays armed and times out again one full interval after the pulse.
- R9: After `rst_n`, `ref_time` increases by one every cycle. It reads zero in the first cycle after a hard reset pulse ends.
- R10: `ref_time` wraps from all ones to zero, and the wrap changes neither `irq` nor `hard_rst`.
- R11: The configuration word `cfg_wdata` has this layout: bit 0 is the watchdog enable, bit 1 is the overflow-reset mask, and bits [INTV_W+1:2] hold the interval I. It takes effect at the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fg_ovf | input | 1 | Foreground stack overflow strobe |
| bg_ovf | input | 1 | Background stack overflow strobe |
| wd_kick | input | 1 | Watchdog kick strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | INTV_W+2 | Configuration word (layout in R11) |
| irq_clr | input | 1 | Clears both overflow flags |
| irq | output | 1 | Stack overflow interrupt |
| hard_rst | output | 1 | Hard reset pulse |
| ref_time | output | TIMER_W | Free-running reference timer |

## Verification
The embedded assertions check on every cycle that a strobe raises the interrupt and that a clear without a strobe drops it. They also check that a double overflow with the mask at 0 raises the reset pulse, and that a masked overflow never does. The pulse generator is checked to hold the pulse while its count is nonzero and never to start one without a trigger.

The bench scenarios cover what needs a longer view. They measure the exact pulse length and the exact cycle of a watchdog timeout, including a kick placed on the last allowed cycle. They also show that the watchdog stays disarmed after power-on, that the configuration survives a hard reset, and that the timer returns to zero after the pulse. A narrow second instance shows the timer wrapping.

// File: rtl/hs_pkg.sv
// Shared definitions for the health supervisor.
// Holds the configuration word bit positions, which the bench also relies on.
package hs_pkg;
    localparam int unsigned CFG_EN_BIT   = 0;
    localparam int unsigned CFG_MASK_BIT = 1;
    localparam int unsigned CFG_INTV_LSB = 2;

    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_HOLD = 1'b1
    } pulse_state_t;
endpackage

// File: rtl/hs_stack_flags.sv
// Sticky overflow flags for the two stacks, plus the interrupt.
// Assumes the strobes are synchronous to clk. clr_all (the hard reset pulse)
// takes priority over everything. A strobe takes priority over irq_clr.
module hs_stack_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic fg_ovf,
    input  logic bg_ovf,
    input  logic irq_clr,
    output logic fg_flag,
    output logic bg_flag,
    output logic irq
);
    // Latch each overflow until it is cleared by software or by a hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            fg_flag <= 1'b0;
            bg_flag <= 1'b0;
        end else begin
            fg_flag <= fg_ovf | (fg_flag & ~irq_clr);
            bg_flag <= bg_ovf | (bg_flag & ~irq_clr);
        end
    end

    // The interrupt is high while either flag is set.
    always_comb irq = fg_flag | bg_flag;

    // R1
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fg_ovf || bg_ovf) && !clr_all) |=> irq);

    // R2
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fg_ovf && !bg_ovf) |=> !irq);
endmodule

// File: rtl/hs_watchdog.sv
// Watchdog down-counter.
// A configuration write loads load_val. Disarmed, kicked or cleared, the
// counter reloads from interval. fire is high in a cycle where the counter
// has reached zero, the watchdog is enabled and no kick is present.
module hs_watchdog #(
    parameter int unsigned INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              enable,
    input  logic [INTV_W-1:0] interval,
    input  logic              load,
    input  logic [INTV_W-1:0] load_val,
    input  logic              kick,
    output logic              fire
);
    logic [INTV_W-1:0] cnt;

    // Count down the time remaining until the next kick is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (clr_all || !enable || kick || cnt == '0) begin
            cnt <= interval;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Flag an expired interval.
    always_comb fire = enable && (cnt == '0) && !kick && !load && !clr_all;
endmodule

// File: rtl/hs_ref_timer.sv
// Free-running reference counter of TIMER_W bits.
// It wraps silently. It is held at zero while clr_all is high.
module hs_ref_timer #(
    parameter int unsigned TIMER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    output logic [TIMER_W-1:0] value
);
    // Advance by one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) value <= '0;
        else                   value <= value + 1'b1;
    end
endmodule

// File: rtl/hs_reset_pulse.sv
// Generates a hard reset pulse of exactly LEN cycles.
// The pulse starts on the edge after trigger is seen. Triggers are ignored
// while a pulse is running. Assumes LEN >= 2.
module hs_reset_pulse
    import hs_pkg::*;
#(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic hard_rst
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    pulse_state_t   state;
    logic [CW-1:0]  cnt;

    // Start on a trigger and count the pulse down to its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PG_IDLE;
            cnt   <= '0;
        end else if (state == PG_IDLE) begin
            if (trigger) begin
                state <= PG_HOLD;
                cnt   <= LAST;
            end
        end else if (cnt == '0) begin
            state <= PG_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Drive the pulse from the state register.
    always_comb hard_rst = (state == PG_HOLD);

    // R5
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_rst && cnt != '0) |=> hard_rst);

    // R5
    pulse_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_rst && !trigger) |=> !hard_rst);
endmodule

// File: rtl/health_supervisor.sv
// Processor health supervisor: stack overflow interrupt and reset, watchdog,
// and reference timer. The configuration word is cleared only by rst_n.
// The hard reset pulse clears all other state.
module health_supervisor
    import hs_pkg::*;
#(
    parameter int unsigned INTV_W    = 16,
    parameter int unsigned TIMER_W   = 24,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fg_ovf,
    input  logic               bg_ovf,
    input  logic               wd_kick,
    input  logic               cfg_we,
    input  logic [INTV_W+1:0]  cfg_wdata,
    input  logic               irq_clr,
    output logic               irq,
    output logic               hard_rst,
    output logic [TIMER_W-1:0] ref_time
);
    logic              cfg_en;
    logic              cfg_mask;
    logic [INTV_W-1:0] cfg_intv;
    logic              fg_flag, bg_flag;
    logic              wd_fire;
    logic              ovf_trig;

    // Hold the configuration word; only rst_n clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_mask <= 1'b0;
            cfg_intv <= '0;
        end else if (cfg_we) begin
            cfg_en   <= cfg_wdata[CFG_EN_BIT];
            cfg_mask <= cfg_wdata[CFG_MASK_BIT];
            cfg_intv <= cfg_wdata[CFG_INTV_LSB +: INTV_W];
        end
    end

    // Request a reset when both stacks have overflowed and the mask is 0.
    always_comb ovf_trig = fg_flag && bg_flag && !cfg_mask;

    hs_stack_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (hard_rst),
        .fg_ovf  (fg_ovf),
        .bg_ovf  (bg_ovf),
        .irq_clr (irq_clr),
        .fg_flag (fg_flag),
        .bg_flag (bg_flag),
        .irq     (irq)
    );

    hs_watchdog #(.INTV_W(INTV_W)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (hard_rst),
        .enable   (cfg_en),
        .interval (cfg_intv),
        .load     (cfg_we),
        .load_val (cfg_wdata[CFG_INTV_LSB +: INTV_W]),
        .kick     (wd_kick),
        .fire     (wd_fire)
    );

    hs_ref_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (hard_rst),
        .value   (ref_time)
    );

    hs_reset_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (ovf_trig || wd_fire),
        .hard_rst (hard_rst)
    );

    // R3
    dual_ovf_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fg_flag && bg_flag && !cfg_mask && !hard_rst) |=> hard_rst);

    // R4
    masked_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask && !wd_fire && !hard_rst) |=> !hard_rst);
endmodule

// File: tb/health_supervisor_test.sv
module health_supervisor_test;
    localparam int unsigned INTV_W = 16;
    localparam int unsigned PLEN   = 16;
    localparam int unsigned IV     = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fg_ovf = 1'b0, bg_ovf = 1'b0, wd_kick = 1'b0, cfg_we = 1'b0, irq_clr = 1'b0;
    logic [INTV_W+1:0] cfg_wdata = '0;
    logic irq, hard_rst;
    logic [23:0] ref_time;
    logic irq_w, rst_w;
    logic [7:0] time_w;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    health_supervisor uut (
        .clk(clk), .rst_n(rst_n), .fg_ovf(fg_ovf), .bg_ovf(bg_ovf),
        .wd_kick(wd_kick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_clr(irq_clr), .irq(irq), .hard_rst(hard_rst), .ref_time(ref_time)
    );

    health_supervisor #(.TIMER_W(8)) uut_w (
        .clk(clk), .rst_n(rst_n), .fg_ovf(1'b0), .bg_ovf(1'b0),
        .wd_kick(1'b0), .cfg_we(1'b0), .cfg_wdata('0),
        .irq_clr(1'b0), .irq(irq_w), .hard_rst(rst_w), .ref_time(time_w)
    );

    // vector: [4] fg_ovf, [3] bg_ovf, [2] irq_clr, [1] expected irq, [0] expected hard_rst
    localparam logic [4:0] VEC [9] = '{
        5'b10010, // R1 foreground strobe sets irq
        5'b00010, // R1 sticky
        5'b00100, // R2 clear
        5'b01010, // R1 background strobe
        5'b01110, // R2 strobe wins over clear
        5'b00100, // R2 clear
        5'b11010, // R4 both, masked
        5'b00010, // R4 still no reset
        5'b00100  // R2 clear
    };

    task automatic cyc();
        @(negedge clk);
        cycles++;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic mask, input logic [INTV_W-1:0] iv);
        cfg_wdata = {iv, mask, en};
        cfg_we = 1'b1;
        cyc();
        cfg_we = 1'b0;
    endtask

    initial begin : watchdog_guard
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int n;
        logic [23:0] t0;
        repeat (3) cyc();
        // reset state
        chk("reset irq", irq, 0);
        chk("reset hard_rst", hard_rst, 0);
        chk("reset ref_time", ref_time, 0);
        rst_n = 1'b1;

        // R9 timer increments by one per cycle
        cyc();
        t0 = ref_time;
        for (int i = 0; i < 5; i++) begin
            cyc();
            chk("R9 increment", ref_time, 32'(t0 + 24'(i + 1)));
        end

        // R6 disarmed after reset: no kicks, no reset
        n = 0;
        for (int i = 0; i < 100; i++) begin
            cyc();
            if (hard_rst) n++;
        end
        chk("R6 disarmed", n, 0);

        // vector table with mask set (R11 bit 1)
        write_cfg(1'b0, 1'b1, 16'd0);
        for (int i = 0; i < 9; i++) begin
            fg_ovf = VEC[i][4];
            bg_ovf = VEC[i][3];
            irq_clr = VEC[i][2];
            cyc();
            fg_ovf = 1'b0; bg_ovf = 1'b0; irq_clr = 1'b0;
            chk("R1/R2/R4 vector irq", irq, 32'(VEC[i][1]));
            chk("R4 vector hard_rst", hard_rst, 32'(VEC[i][0]));
        end

        // R3 both overflows, mask clear
        write_cfg(1'b0, 1'b0, 16'd0);
        fg_ovf = 1'b1; cyc(); fg_ovf = 1'b0;
        chk("R3 no reset on one", hard_rst, 0);
        bg_ovf = 1'b1; cyc(); bg_ovf = 1'b0;
        chk("R3 not yet", hard_rst, 0);
        cyc();
        chk("R3 reset rises", hard_rst, 1);
        // R5 strobe during pulse ignored, measure length
        fg_ovf = 1'b1; cyc(); fg_ovf = 1'b0;
        n = 2;
        while (hard_rst && n < 100) begin
            cyc();
            if (hard_rst) n++;
        end
        chk("R5 pulse length", n, PLEN);
        chk("R5 irq after pulse", irq, 0);
        chk("R9 timer zero after pulse", ref_time, 0);

        // R7 kick on the last allowed cycle, then timeout
        write_cfg(1'b1, 1'b0, 16'(IV));
        n = 0;
        for (int i = 0; i < IV; i++) begin
            cyc();
            if (hard_rst) n++;
        end
        wd_kick = 1'b1; cyc(); wd_kick = 1'b0;
        chk("R7 kick in time", n + int'(hard_rst), 0);
        n = 0;
        for (int i = 0; i < IV; i++) begin
            cyc();
            if (hard_rst) n++;
        end
        chk("R7 no early timeout", n, 0);
        cyc();
        chk("R7 timeout", hard_rst, 1);
        n = 1;
        while (hard_rst && n < 100) begin
            cyc();
            if (hard_rst) n++;
        end
        chk("R5 watchdog pulse length", n, PLEN);

        // R8 configuration kept: watchdog times out again after one interval
        n = 0;
        for (int i = 0; i < IV; i++) begin
            cyc();
            if (hard_rst) n++;
        end
        chk("R8 quiet interval", n, 0);
        cyc();
        chk("R8 still armed", hard_rst, 1);
        while (hard_rst) cyc();
        write_cfg(1'b0, 1'b0, 16'd0);

        // R10 wrap on the 8-bit instance
        n = 0;
        while (time_w != 8'hFF && n < 300) begin
            cyc();
            n++;
        end
        cyc();
        chk("R10 wrap to zero", time_w, 0);
        chk("R10 no irq", irq_w, 0);
        chk("R10 no reset", rst_w, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule